// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for every received Ethernet frame, whether its 48-bit destination address lets the frame through to the host. The receive path presents the address with a one-cycle valid strobe. Two clock edges later the block returns a registered verdict: an accept flag and a destination-filter-fail status bit.

The rules combine several parts. Unicast frames are matched exactly against a primary station address and up to sixteen additional entries, and each additional entry can be switched on or off. Group-addressed frames go through a 64-bin hash built from the Ethernet CRC32, or through a pass-all-multicast mode. Broadcast frames have a separate disable bit. A promiscuous mode admits everything. A receive-all mode forwards every frame to the host while the fail bit still reports what the filter decided.

Configuration is a flat word-write port. A single write strobe, an index and a 32-bit data word load the mode bits, the two hash words and the address entries. Each write takes effect for frames presented in any cycle after the write cycle.

Top module: `rx_da_filter`

## Requirements
- R1: `out_valid` rises exactly two rising clock edges after `da_valid` is sampled high, and one decision per cycle is sustained for back-to-back addresses.
- R2: After reset all configuration is zero. While `out_valid` is low, `out_accept` and `out_da_fail` are both low.
- R3: The address byte that arrives first on the wire sits in `da[7:0]`. A unicast address (`da[0]`=0) passes when it equals entry 0 or any enabled extra entry. Entry 0 is always enabled.
- R4: An extra entry (index 1 to 16) whose enable bit is clear never matches.
- R5: The hash index is computed in three steps. Take the reflected Ethernet CRC32 (polynomial 0xEDB88320, start value all ones, final complement) over the six address bytes, first byte first. Reverse the bit order of the result. Keep bits 31:26.
- R6: With hash-multicast mode on, a group address passes when bit [index] of the 64-bit table is set. Index bit 5 = 1 selects the high word, 0 selects the low word, and index bits 4:0 pick the bit within the word.
- R7: With pass-all-multicast mode on, every address with `da[0]`=1 passes.
- R8: The all-ones broadcast address passes unless the broadcast-disable bit is set. It can still pass through R6 or R7.
- R9: With promiscuous mode on, every address passes and the fail bit stays low.
- R10: With receive-all mode on, `out_accept` is 1 for every frame, and `out_da_fail` still shows whether the rules rejected it.
- R11: Otherwise `out_accept` equals the rule outcome and `out_da_fail` is its inverse. Group addresses are never matched by the exact-match entries.
- R12: Configuration write map, by index:
  - 0: mode bits, where bit0 = promiscuous, bit1 = pass-all-multicast, bit2 = hash-multicast, bit3 = broadcast-disable and bit4 = receive-all.
  - 1: hash low word.
  - 2: hash high word.
  - 4+2n: `da[31:0]` of entry n.
  - 5+2n: `da[47:32]` of entry n in bits 15:0, with the enable in bit 31.

  A write affects frames presented from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW (6) | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, first wire byte in bits 7:0 |
| out_valid | output | 1 | Verdict valid |
| out_accept | output | 1 | Frame goes to the host |
| out_da_fail | output | 1 | Destination filter rejected the frame |

## Verification
The checks on the promiscuous and receive-all outputs assume that the mode word stays put while a frame is in flight. They also assume that `da_valid` is low during reset, so that the two-cycle latency check starts from an empty pipeline. The bench writes configuration only in cycles with no new address, and keeps `da_valid` low throughout reset. Its expected verdicts come from a shadow copy of the configuration that is updated in the same cycle as each write. This reproduces the rule that a write affects only frames presented after it.

// File: rtl/rx_da_filter_pkg.sv
package rx_da_filter_pkg;
    localparam int DA_W       = 48;
    localparam int WORD_W     = 32;
    localparam int HASH_IDX_W = 6;
    localparam int HASH_BINS  = 1 << HASH_IDX_W;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

    // configuration word indices
    localparam int CFG_MODE     = 0;
    localparam int CFG_HASH_LO  = 1;
    localparam int CFG_HASH_HI  = 2;
    localparam int CFG_ENT_BASE = 4;
    localparam int ENT_EN_BIT   = 31;

    // bit0 promisc ... bit4 rx_all
    typedef struct packed {
        logic rx_all;
        logic bcast_dis;
        logic hash_mc;
        logic pass_mc;
        logic promisc;
    } mode_t;
    localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/da_hash_index.sv
module da_hash_index
    import rx_da_filter_pkg::*;
#(
    parameter int AW = DA_W,
    parameter int IW = HASH_IDX_W
) (
    input  logic [AW-1:0] da,
    output logic [IW-1:0] idx
);
    always_comb begin
        logic [31:0] crc;
        logic        fb;
        crc = '1;
        // serial reflected CRC, wire order = da[0] first
        for (int b = 0; b < AW; b++) begin
            fb  = crc[0] ^ da[b];
            crc = {1'b0, crc[31:1]} ^ (fb ? CRC_POLY_REFL : 32'h0);
        end
        crc = ~crc;
        // top bits of the bit-reversed value = low bits reversed
        for (int k = 0; k < IW; k++) begin
            idx[IW-1-k] = crc[k];
        end
    end
endmodule

// File: rtl/da_perfect_match.sv
module da_perfect_match
    import rx_da_filter_pkg::*;
#(
    parameter int N_ENT = 17,
    parameter int AW    = DA_W
) (
    input  logic [N_ENT-1:0][AW-1:0] ent_addr,
    input  logic [N_ENT-1:0]         ent_en,
    input  logic [AW-1:0]            da,
    output logic                     hit
);
    logic [N_ENT-1:0] hit_vec;

    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        assign hit_vec[e] = ent_en[e] && (ent_addr[e] == da);
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/da_cfg_regs.sv
module da_cfg_regs
    import rx_da_filter_pkg::*;
#(
    parameter int N_ENT  = 17,
    parameter int CFG_AW = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [CFG_AW-1:0]           cfg_addr,
    input  logic [WORD_W-1:0]           cfg_wdata,
    output logic [N_ENT-1:0][DA_W-1:0]  ent_addr,
    output logic [N_ENT-1:0]            ent_en,
    output logic [HASH_BINS-1:0]        hash_tbl,
    output mode_t                       mode
);
    typedef struct packed {
        logic [N_ENT-1:0][DA_W-1:0] addr;
        logic [N_ENT-1:0]           en;
        logic [HASH_BINS-1:0]       hash;
        mode_t                      mode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            if (cfg_addr == CFG_AW'(CFG_MODE))
                cfg_d.mode = mode_t'(cfg_wdata[MODE_W-1:0]);
            if (cfg_addr == CFG_AW'(CFG_HASH_LO))
                cfg_d.hash[WORD_W-1:0] = cfg_wdata;
            if (cfg_addr == CFG_AW'(CFG_HASH_HI))
                cfg_d.hash[HASH_BINS-1:WORD_W] = cfg_wdata;
            for (int e = 0; e < N_ENT; e++) begin
                if (cfg_addr == CFG_AW'(CFG_ENT_BASE + 2*e))
                    cfg_d.addr[e][WORD_W-1:0] = cfg_wdata;
                if (cfg_addr == CFG_AW'(CFG_ENT_BASE + 2*e + 1)) begin
                    cfg_d.addr[e][DA_W-1:WORD_W] = cfg_wdata[DA_W-WORD_W-1:0];
                    cfg_d.en[e] = (e != 0) && cfg_wdata[ENT_EN_BIT];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign ent_addr = cfg_q.addr;
    assign ent_en   = cfg_q.en | N_ENT'(1);
    assign hash_tbl = cfg_q.hash;
    assign mode     = cfg_q.mode;

    // R12
    mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == CFG_AW'(CFG_MODE)) |=> (mode == $past(cfg_wdata[MODE_W-1:0])));
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
    import rx_da_filter_pkg::*;
#(
    parameter int N_EXTRA = 16,
    parameter int CFG_AW  = $clog2(CFG_ENT_BASE + 2*(N_EXTRA+1))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              da_valid,
    input  logic [47:0]       da,
    output logic              out_valid,
    output logic              out_accept,
    output logic              out_da_fail
);
    localparam int N_ENT = N_EXTRA + 1;

    typedef struct packed {
        logic                  vld;
        logic                  grp;
        logic                  bcast;
        logic                  uc_hit;
        logic [HASH_IDX_W-1:0] idx;
    } s1_t;

    typedef struct packed {
        logic vld;
        logic acc;
        logic fail;
    } s2_t;

    logic [N_ENT-1:0][DA_W-1:0] ent_addr;
    logic [N_ENT-1:0]           ent_en;
    logic [HASH_BINS-1:0]       hash_tbl;
    mode_t                      mode_w;
    logic [HASH_IDX_W-1:0]      idx_w;
    logic                       hit_w;
    logic                       pass_w;

    s1_t s1_d, s1_q;
    s2_t s2_d, s2_q;

    da_cfg_regs #(.N_ENT(N_ENT), .CFG_AW(CFG_AW)) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .ent_addr (ent_addr),
        .ent_en   (ent_en),
        .hash_tbl (hash_tbl),
        .mode     (mode_w)
    );

    da_hash_index #(.AW(DA_W), .IW(HASH_IDX_W)) hash_i (
        .da (da),
        .idx(idx_w)
    );

    da_perfect_match #(.N_ENT(N_ENT), .AW(DA_W)) match_i (
        .ent_addr(ent_addr),
        .ent_en  (ent_en),
        .da      (da),
        .hit     (hit_w)
    );

    always_comb begin
        s1_d.vld    = da_valid;
        s1_d.grp    = da_valid & da[0];
        s1_d.bcast  = da_valid & (&da);
        s1_d.uc_hit = da_valid & ~da[0] & hit_w;
        s1_d.idx    = da_valid ? idx_w : '0;

        pass_w = mode_w.promisc
               | s1_q.uc_hit
               | (s1_q.grp & (mode_w.pass_mc
                             | (mode_w.hash_mc & hash_tbl[s1_q.idx])
                             | (s1_q.bcast & ~mode_w.bcast_dis)));

        s2_d.vld  = s1_q.vld;
        s2_d.acc  = s1_q.vld & (pass_w | mode_w.rx_all);
        s2_d.fail = s1_q.vld & ~pass_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_valid   = s2_q.vld;
    assign out_accept  = s2_q.acc;
    assign out_da_fail = s2_q.fail;

    // R1
    lat_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid |-> ##2 out_valid);
    // R1
    lat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !da_valid |-> ##2 !out_valid);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_accept && !out_da_fail));
    // R9
    promisc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode_w.promisc && $past(mode_w.promisc)) |-> (out_accept && !out_da_fail));
    // R10
    rx_all_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode_w.rx_all && $past(mode_w.rx_all)) |-> out_accept);
endmodule

// File: tb/rx_da_filter_tb_top.sv
module rx_da_filter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_ENT      = 17;
    localparam int CAW        = 6;
    localparam logic [31:0] POLY = 32'hEDB8_8320;

    logic           clk = 0;
    logic           rst_n = 0;
    logic           cfg_we = 0;
    logic [CAW-1:0] cfg_addr = '0;
    logic [31:0]    cfg_wdata = '0;
    logic           da_valid = 0;
    logic [47:0]    da = '0;
    logic           out_valid, out_accept, out_da_fail;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_da_filter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da(da),
        .out_valid(out_valid), .out_accept(out_accept), .out_da_fail(out_da_fail)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    // shadow configuration
    logic [47:0] sh_addr [N_ENT];
    bit          sh_en   [N_ENT];
    logic [63:0] sh_hash = '0;
    logic [4:0]  sh_mode = '0;

    // pending write
    bit          wr_req = 0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;

    // expectation pipe
    bit ev0 = 0, ea0 = 0, ef0 = 0, ev1 = 0, ea1 = 0, ef1 = 0;
    string tg0 = "R2", tg1 = "R2";

    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        logic [31:0] r;
        for (int i = 0; i < 6; i++) begin
            c ^= {24'h0, a[8*i +: 8]};
            for (int j = 0; j < 8; j++)
                c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
        end
        c = ~c;
        for (int i = 0; i < 32; i++) r[31-i] = c[i];
        return r[31:26];
    endfunction

    function automatic void model(input logic [47:0] a, output bit acc, output bit fail);
        bit grp = a[0];
        bit bc  = (a == 48'hFFFF_FFFF_FFFF);
        bit hit = 0;
        bit pass;
        for (int e = 0; e < N_ENT; e++)
            if ((e == 0 || sh_en[e]) && sh_addr[e] == a && !grp) hit = 1;
        pass = sh_mode[0] || hit ||
               (grp && (sh_mode[1] || (sh_mode[2] && sh_hash[ref_idx(a)]) || (bc && !sh_mode[3])));
        acc  = pass || sh_mode[4];
        fail = !pass;
    endfunction

    task automatic step(input bit v, input logic [47:0] a, input string tag);
        bit ea, ef;
        @(negedge clk);
        total++;
        if (out_valid !== ev1 || out_accept !== ea1 || out_da_fail !== ef1) begin
            bad++;
            $display("FAIL %s: valid/accept/fail actual=%0b%0b%0b expected=%0b%0b%0b",
                     tg1, out_valid, out_accept, out_da_fail, ev1, ea1, ef1);
        end
        ev1 = ev0; ea1 = ea0; ef1 = ef0; tg1 = tg0;
        ea = 0; ef = 0;
        if (v) model(a, ea, ef);
        ev0 = v; ea0 = ea; ef0 = ef; tg0 = v ? tag : "R2";
        cfg_we    = wr_req;
        cfg_addr  = wr_addr;
        cfg_wdata = wr_data;
        wr_req    = 0;
        da_valid  = v;
        da        = a;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, "R2");
    endtask

    task automatic cfg_write(input int idx, input logic [31:0] d);
        wr_req = 1; wr_addr = 6'(idx); wr_data = d;
        step(0, '0, "R12");
        if (idx == 0) sh_mode = d[4:0];
        else if (idx == 1) sh_hash[31:0] = d;
        else if (idx == 2) sh_hash[63:32] = d;
        else if (idx >= 4) begin
            if (idx % 2 == 0) sh_addr[(idx-4)/2][31:0] = d;
            else begin
                sh_addr[(idx-5)/2][47:32] = d[15:0];
                sh_en[(idx-5)/2] = d[31];
            end
        end
    endtask

    function automatic logic [47:0] ent_val(input int e);
        return {16'h00C0 ^ 16'(e * 37), 16'h2468, 8'(e), 8'h40};
    endfunction

    function automatic logic [47:0] mc_val(input int k);
        return {8'(k * 7), 8'(k), 16'hBEEF ^ 16'(k * 977), 8'h5E, 8'((k << 1) | 1)};
    endfunction

    initial begin
        for (int e = 0; e < N_ENT; e++) begin sh_addr[e] = '0; sh_en[e] = 0; end
        // R2 reset state
        idle(4);
        rst_n = 1;
        idle(2);
        // R2: all-zero entry 0 matches zero address after reset
        step(1, 48'h0, "R2");
        // R3 / R4 exact match entries, odd extras enabled
        for (int e = 0; e < N_ENT; e++) begin
            cfg_write(4 + 2*e, ent_val(e)[31:0]);
            cfg_write(5 + 2*e, {(e % 2 == 1), 15'h0, ent_val(e)[47:32]});
        end
        for (int e = 0; e < N_ENT; e++)
            step(1, ent_val(e), (e == 0 || e % 2 == 1) ? "R3" : "R4");
        // R11 non-matching unicast, back-to-back (R1)
        for (int k = 0; k < 8; k++)
            step(1, ent_val(k) ^ 48'h0100_0000_0000, "R11");
        // R3 entry 0 ignores its enable bit
        cfg_write(5, {1'b0, 15'h0, ent_val(0)[47:32]});
        step(1, ent_val(0), "R3");
        // R11 group address equal to an entry is not exact-matched
        cfg_write(4 + 2*3, ent_val(3)[31:0] | 32'h1);
        step(1, ent_val(3) | 48'h1, "R11");
        // R5 / R6 hash sweep, two complementary tables
        cfg_write(0, 32'h4);
        cfg_write(1, 32'h5A5A_C3C3);
        cfg_write(2, 32'h0F0F_9669);
        for (int k = 0; k < 96; k++) step(1, mc_val(k), "R5/R6");
        cfg_write(1, ~32'h5A5A_C3C3);
        cfg_write(2, ~32'h0F0F_9669);
        for (int k = 0; k < 96; k++) step(1, mc_val(k), "R5/R6");
        // R6 only high word set, then only low word set
        cfg_write(1, 32'h0);
        cfg_write(2, 32'hFFFF_FFFF);
        for (int k = 0; k < 32; k++) step(1, mc_val(k + 200), "R6");
        cfg_write(1, 32'hFFFF_FFFF);
        cfg_write(2, 32'h0);
        for (int k = 0; k < 32; k++) step(1, mc_val(k + 200), "R6");
        // R11 hash off, multicast rejected
        cfg_write(0, 32'h0);
        for (int k = 0; k < 8; k++) step(1, mc_val(k), "R11");
        // R7 pass-all multicast
        cfg_write(0, 32'h2);
        for (int k = 0; k < 16; k++) step(1, mc_val(k), "R7");
        step(1, ent_val(2), "R7");
        // R8 broadcast
        cfg_write(0, 32'h0);
        step(1, 48'hFFFF_FFFF_FFFF, "R8");
        cfg_write(0, 32'h8);
        step(1, 48'hFFFF_FFFF_FFFF, "R8");
        cfg_write(0, 32'hA);
        step(1, 48'hFFFF_FFFF_FFFF, "R8");
        // R9 promiscuous
        cfg_write(0, 32'h1);
        for (int k = 0; k < 16; k++) step(1, (k % 2) ? mc_val(k) : ent_val(k) ^ 48'hFF00_0000_0000, "R9");
        // R10 receive-all
        cfg_write(0, 32'h10);
        step(1, ent_val(1), "R10");
        step(1, ent_val(2), "R10");
        step(1, mc_val(5), "R10");
        step(1, 48'hFFFF_FFFF_FFFF, "R10");
        // R12 write takes effect on the very next frame
        cfg_write(0, 32'h8);
        step(1, 48'hFFFF_FFFF_FFFF, "R12");
        cfg_write(0, 32'h0);
        step(1, 48'hFFFF_FFFF_FFFF, "R12");
        idle(4);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R1: watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule